// File: doc/BRIEF.md
# Byte-Framed Serial ADC Reader

This block is a host-side serial master that fetches one 12-bit conversion from a two-channel successive-approximation converter. It runs the exchange as three 8-bit groups, the way a byte-oriented serial port would. The start bit is padded with leading zeros so that the result lands in the low 12 bits of the last two received bytes. A request carries the channel configuration (single-ended or differential, channel/polarity select, and the bit-order flag) and the clock polarity for the exchange. The block then drives chip select, the serial clock and the command line, and shifts in the reply.

When the exchange ends, the block drops everything in the reply except the twelve data bits and the null bit. Three leading reply bits of the middle byte come from an undriven line and are never used. The result and a null-bit error flag update together with a one-cycle done pulse, and they hold until the next exchange completes. The clock half-period, the chip-select setup time and the minimum chip-select high time are set by parameters in nanoseconds. Each is rounded up to whole system-clock cycles.

Top module: `adc_frame_reader`

## Requirements
- R1: During and after reset, with no request: chip select high, serial clock low, done low, ready high, result 0 and error flag 0.
- R2: The first eight bits sent on the command line are 0000_0001, with the start bit last.
- R3: The next three bits sent after the start bit are, in order, single-ended select, odd/sign select and bit-order flag.
- R4: The result is the 12 reply bits that follow the null bit, MSB first. These are the low nibble of the second received byte, then the whole third byte. The top three bits of the second received byte have no effect on the result.
- R5: The error flag equals the null bit, which is bit 4 of the second received byte; a 1 there raises the flag.
- R6: The command line changes only while the serial clock is low or idle, and the reply is sampled on rising edges. With polarity 0 the clock idles low; with polarity 1 it idles high whenever chip select is high.
- R7: Every high and low phase of the serial clock inside an exchange lasts at least ceil(MIN_PHASE_NS / SYS_PERIOD_NS) system cycles.
- R8: At least ceil(CS_SETUP_NS / SYS_PERIOD_NS) system cycles pass from chip select falling to the first rising clock edge.
- R9: Chip select stays high for at least ceil(CS_GAP_NS / SYS_PERIOD_NS) cycles between exchanges. Requests made while ready is low are ignored.
- R10: Done is high for exactly one cycle, in the first cycle chip select is high again. The result and flag hold their value until the next done.
- R11: Each exchange has exactly 24 rising clock edges while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an exchange when ready is high |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_odd | input | 1 | Channel select or differential polarity |
| req_msbf | input | 1 | Bit-order flag forwarded to the converter |
| req_cpol | input | 1 | Serial clock idle level for this exchange |
| req_ready | output | 1 | Idle and chip-select high time served |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Command bits to the converter |
| spi_miso | input | 1 | Reply bits from the converter |
| done | output | 1 | One-cycle completion pulse |
| result | output | 12 | Assembled conversion code |
| null_err | output | 1 | Null bit was sampled as 1 |

## Verification
Two events share one cycle here. Chip select returns high in the same cycle that done rises and the result register loads. A request also arrives while the chip-select high timer is still running. The bench holds the request line active for ten cycles just after each done. It checks that chip select stays high, that ready stays low and that the new result does not move. The bench also drives ones on the three undriven reply bits and on the null bit across a sweep of all eight configurations in both clock polarities. This separates masking errors from null-bit errors.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
    localparam int FRAME_BITS  = 24;
    localparam int RESULT_BITS = 12;
    localparam logic [7:0] LEAD_BYTE = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } afr_state_e;
endpackage

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_frame_pkg::*;
#(
    parameter int SYS_PERIOD_NS = 10,
    parameter int MIN_PHASE_NS  = 250,
    parameter int CS_SETUP_NS   = 100,
    parameter int CS_GAP_NS     = 500
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_single,
    input  logic        req_odd,
    input  logic        req_msbf,
    input  logic        req_cpol,
    output logic        req_ready,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        done,
    output logic [11:0] result,
    output logic        null_err
);
    // cycle counts, rounded up so no interval falls below its minimum
    localparam int HALF_CYC  = (MIN_PHASE_NS + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
    localparam int SETUP_CYC = (CS_SETUP_NS + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
    localparam int GAP_CYC   = (CS_GAP_NS + SYS_PERIOD_NS - 1) / SYS_PERIOD_NS;
    localparam int MAX_A     = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
    localparam int MAX_CYC   = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
    localparam int CW        = $clog2(MAX_CYC + 1);
    localparam int BW        = $clog2(FRAME_BITS);
    localparam int RXW       = RESULT_BITS + 1;

    typedef struct packed {
        afr_state_e             st;
        logic [CW-1:0]          cnt;
        logic [BW-1:0]          bit_idx;
        logic [FRAME_BITS-1:0]  tx;
        logic [RXW-1:0]         rx;
        logic                   cpol;
        logic                   cs_n;
        logic                   sclk;
        logic                   done;
        logic                   nerr;
        logic [RESULT_BITS-1:0] result;
    } afr_regs_t;

    afr_regs_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.tx   = {LEAD_BYTE, req_single, req_odd, req_msbf,
                                {(FRAME_BITS - 11){1'b0}}};
                    r_d.cpol = req_cpol;
                    r_d.sclk = req_cpol;
                    r_d.st   = ST_ARM;
                end
            end
            ST_ARM: begin
                r_d.cs_n    = 1'b0;
                r_d.cnt     = '0;
                r_d.bit_idx = '0;
                r_d.st      = ST_SETUP;
            end
            ST_SETUP: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(SETUP_CYC - 1)) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b0;
                    r_d.st   = ST_LOW;
                end
            end
            ST_LOW: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(HALF_CYC - 1)) begin
                    r_d.cnt  = '0;
                    r_d.sclk = 1'b1;
                    r_d.rx   = {r_q.rx[RXW-2:0], spi_miso};
                    r_d.st   = ST_HIGH;
                end
            end
            ST_HIGH: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(HALF_CYC - 1)) begin
                    r_d.cnt = '0;
                    r_d.tx  = {r_q.tx[FRAME_BITS-2:0], 1'b0};
                    if (r_q.bit_idx == BW'(FRAME_BITS - 1)) begin
                        r_d.sclk = r_q.cpol;
                        r_d.st   = ST_TAIL;
                    end else begin
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.sclk    = 1'b0;
                        r_d.st      = ST_LOW;
                    end
                end
            end
            ST_TAIL: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(HALF_CYC - 1)) begin
                    r_d.cnt    = '0;
                    r_d.cs_n   = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.result = r_q.rx[RESULT_BITS-1:0];
                    r_d.nerr   = r_q.rx[RESULT_BITS];
                    r_d.st     = ST_GAP;
                end
            end
            ST_GAP: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CW'(GAP_CYC - 1)) begin
                    r_d.cnt = '0;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign spi_cs_n  = r_q.cs_n;
    assign spi_sclk  = r_q.sclk;
    assign spi_mosi  = r_q.tx[FRAME_BITS-1];
    assign done      = r_q.done;
    assign result    = r_q.result;
    assign null_err  = r_q.nerr;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R10
    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> spi_cs_n);                                          // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(null_err)));           // R10
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sclk == r_q.cpol));                        // R6
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $rose(spi_sclk)) |-> $stable(spi_mosi));       // R6
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && !done));                          // R9
endmodule

// File: tb/test_adc_frame_reader.sv
module test_adc_frame_reader;
    localparam int HALF  = 25;
    localparam int SETUP = 10;
    localparam int GAP   = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_single = 1'b0, req_odd = 1'b0;
    logic req_msbf = 1'b0, req_cpol = 1'b0;
    logic req_ready, spi_cs_n, spi_sclk, spi_mosi, spi_miso, done, null_err;
    logic [11:0] result;

    always #5 clk = ~clk;

    adc_frame_reader i_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_single(req_single),
        .req_odd(req_odd), .req_msbf(req_msbf), .req_cpol(req_cpol),
        .req_ready(req_ready), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done),
        .result(result), .null_err(null_err)
    );

    int tests = 0;
    int fails = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // converter model: reply bit j is presented until the j-th rising edge
    logic [11:0] exp_val = '0;
    logic        exp_null = 1'b0;
    int          rise_cnt = 0;
    int          last_rises = 0;
    logic [23:0] mosi_sh = '0;

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (rise_cnt != 0) last_rises <= rise_cnt;
            rise_cnt <= 0;
        end else begin
            rise_cnt <= rise_cnt + 1;
        end
    end

    always @(posedge spi_sclk) begin
        if (!spi_cs_n) mosi_sh <= {mosi_sh[22:0], spi_mosi};
    end

    always_comb begin
        if (rise_cnt < 11)       spi_miso = 1'b1;       // undriven line
        else if (rise_cnt == 11) spi_miso = exp_null;
        else if (rise_cnt < 24)  spi_miso = exp_val[23 - rise_cnt];
        else                     spi_miso = 1'b0;
    end

    // timing monitor
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;
    int   run = 0, cs_hi_run = 0, setup_run = 0;
    bit   seen = 1'b0, pend = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!spi_cs_n) begin
                if (prev_cs) begin
                    check(cs_hi_run >= GAP, "R9 cs high time", cs_hi_run, GAP);
                    setup_run = 1; pend = 1'b1; seen = 1'b0; run = 1;
                end else begin
                    if (spi_sclk != prev_sclk) begin
                        if (seen) check(run >= HALF, "R7 phase length", run, HALF);
                        if (spi_sclk && pend) begin
                            check(setup_run >= SETUP, "R8 cs setup", setup_run, SETUP);
                            pend = 1'b0;
                        end
                        seen = 1'b1; run = 1;
                    end else begin
                        run++;
                    end
                    if (pend) setup_run++;
                end
                cs_hi_run = 0;
            end else begin
                cs_hi_run++;
            end
            if (done) check(spi_cs_n == 1'b1, "R10 done with cs high", spi_cs_n, 1);
            if (done && prev_done) check(1'b0, "R10 done width", 2, 1);
            prev_sclk = spi_sclk; prev_cs = spi_cs_n; prev_done = done;
        end
    end

    task automatic run_tx(input bit sgl, input bit odd, input bit msbf, input bit cpol,
                          input logic [11:0] val, input bit nul);
        logic [2:0] cfg;
        cfg = {sgl, odd, msbf};
        while (!req_ready) @(negedge clk);
        exp_val = val; exp_null = nul;
        req_single = sgl; req_odd = odd; req_msbf = msbf; req_cpol = cpol;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        check(result == val, "R4 result", result, val);
        check(null_err == nul, "R5 null flag", null_err, nul);
        check(mosi_sh[23:16] == 8'h01, "R2 lead byte", mosi_sh[23:16], 8'h01);
        check(mosi_sh[15:13] == cfg, "R3 config bits", mosi_sh[15:13], cfg);
        check(last_rises == 24, "R11 rising edges", last_rises, 24);
        check(spi_sclk == cpol, "R6 idle level", spi_sclk, cpol);
        // request during the chip-select high window must be ignored
        req_single = ~sgl; req_odd = ~odd; req_cpol = ~cpol; req_valid = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(spi_cs_n && !req_ready, "R9 early request ignored", {spi_cs_n, req_ready}, 2);
        end
        req_valid = 1'b0; req_cpol = cpol;
        check(result == val, "R10 result held", result, val);
        check(null_err == nul, "R10 flag held", null_err, nul);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && done == 1'b0,
              "R1 reset pins", {spi_cs_n, spi_sclk, done}, 3'b100);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(req_ready == 1'b1 && result == 12'h0 && null_err == 1'b0,
              "R1 idle state", {req_ready, result, null_err}, 14'h2000);
        for (int idx = 0; idx < 16; idx++) begin
            logic [11:0] v;
            v = 12'((idx * 273 + 17 * idx * idx) & 12'hFFF);
            run_tx(idx[2], idx[1], idx[0], idx[3], v, (idx % 5) == 3);
        end
        run_tx(1'b0, 1'b0, 1'b0, 1'b0, 12'hFFF, 1'b1);
        run_tx(1'b1, 1'b1, 1'b1, 1'b1, 12'h800, 1'b0);
        run_tx(1'b0, 1'b1, 1'b0, 1'b1, 12'h001, 1'b1);
        report();
    end
endmodule